// File: doc/BRIEF.md
# Two-Stage Display Frame Clock Divider

This block derives the slow timing reference for a display frame from a fast input clock. It does so in two cascaded stages, and all of its logic runs on that single clock. The first stage is a 16-bit counter. A 4-bit power-of-two selector picks one of its taps, so it emits a one-cycle strobe every 2^PS input cycles. The second stage counts those strobes and divides them by an integer from 16 to 31, which is 16 plus a second 4-bit field. The result is an overall division of 2^PS × (16 + DIV).

Two outputs are provided. The first is a single-cycle enable pulse at the final rate, for logic that runs on the main clock. The second is a registered square-wave level that flips on each pulse. Both configuration fields are held in shadow copies, and those copies reload only when the fine stage completes a count, so a period that is already running keeps its length. Dropping the enable clears both counters and forces both outputs low. While the enable is low the shadow copies follow the inputs, so the first period after the enable rises uses the fields presented at that moment.

Top module: `dclk_divider`

## Requirements
- R1: While `rst_n` is low, or on the cycle after `en` has been sampled low, `out_pulse` and `out_level` are both 0.
- R2: With `ps_sel`=0 and `div_sel`=0, `out_pulse` is asserted once every 16 input cycles.
- R3: While `en` stays high and the fields are unchanged, consecutive `out_pulse` assertions are exactly 2^ps_sel × (16 + div_sel) input cycles apart.
- R4: `out_pulse` is first seen high exactly 2^ps_sel × (16 + div_sel) rising edges after the first rising edge at which `en` is sampled high.
- R5: `out_pulse` is high for exactly one cycle per period.
- R6: `out_level` is 0 when counting starts and inverts on exactly the cycles in which `out_pulse` is high.
- R7: A change to `ps_sel` or `div_sel` while `en` is high leaves the period in progress at its old length. The change takes effect from the period that begins at the next pulse.
- R8: Dropping `en` in the middle of a period discards the partial count. After re-enabling, the first pulse follows R4.
- R9: With `div_sel`=15, the fine stage counts 31 prescaler strobes per output pulse and never exceeds its limit of 15 + `div_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears counters and outputs |
| ps_sel | input | 4 | Power-of-two prescaler tap selector |
| div_sel | input | 4 | Fine divide field; ratio is 16 + div_sel |
| out_pulse | output | 1 | One-cycle enable at the final rate |
| out_level | output | 1 | Square wave toggling on each pulse |

## Verification
The bench targets the extremes of both fields. With both fields at 0 the tap is taken on every cycle; a design that mishandles this case would stall or double the period. With `div_sel` at 15 an off-by-one in the fine limit would yield 30 or 32 strobes. A mid-period change of the fields is applied to check the reload point: a design without shadow copies would produce one period of the wrong length. The bench also drops the enable mid-count, because a design that keeps its partial count would deliver the first pulse early after re-enabling. In each of these cases it checks the first-pulse latency and the one-cycle pulse width, since a design off by one register stage would show the pulse one cycle late or hold it high for two cycles.

// File: rtl/dclk_pkg.sv
package dclk_pkg;
    localparam int unsigned PS_W_DEF   = 4;
    localparam int unsigned DIV_W_DEF  = 4;
    localparam int unsigned PRE_W_DEF  = 16;
    localparam int unsigned BASE_DEF   = 16;
endpackage

// File: rtl/dclk_prescale.sv
module dclk_prescale #(
    parameter int unsigned PRE_W = dclk_pkg::PRE_W_DEF,
    parameter int unsigned PS_W  = dclk_pkg::PS_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clear,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] tap_mask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            tap_mask[i] = (i < int'(ps));
        end
        tick = run && ((st_q.cnt & tap_mask) == tap_mask);
        st_d = st_q;
        if (!run || clear) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A strobe at a tap above zero is never followed by another strobe on the next cycle
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ps != '0) |=> (!tick || ps == '0));

    // Tap zero strobes on every running cycle
    assert_tick_every_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ps == '0) |-> tick);
endmodule

// File: rtl/dclk_fine.sv
module dclk_fine #(
    parameter int unsigned DIV_W = dclk_pkg::DIV_W_DEF,
    parameter int unsigned BASE  = dclk_pkg::BASE_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    output logic             wrap
);
    localparam int unsigned CW = $clog2(BASE + (1 << DIV_W));

    typedef struct packed {
        logic [CW-1:0] cnt;
    } fine_state_t;

    fine_state_t st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = CW'(BASE - 1) + CW'(div);
        wrap  = run && tick && (st_q.cnt == limit);
        st_d  = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Count never passes the active limit
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= limit);
endmodule

// File: rtl/dclk_divider.sv
module dclk_divider #(
    parameter int unsigned PRE_W = dclk_pkg::PRE_W_DEF,
    parameter int unsigned PS_W  = dclk_pkg::PS_W_DEF,
    parameter int unsigned DIV_W = dclk_pkg::DIV_W_DEF,
    parameter int unsigned BASE  = dclk_pkg::BASE_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PS_W-1:0]  ps_sel,
    input  logic [DIV_W-1:0] div_sel,
    output logic             out_pulse,
    output logic             out_level
);
    typedef struct packed {
        logic [PS_W-1:0]  ps_sh;
        logic [DIV_W-1:0] div_sh;
        logic             pulse;
        logic             level;
    } top_state_t;

    top_state_t st_d, st_q;
    logic pre_tick;
    logic fine_wrap;

    dclk_prescale #(.PRE_W(PRE_W), .PS_W(PS_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en),
        .clear (fine_wrap),
        .ps    (st_q.ps_sh),
        .tick  (pre_tick)
    );

    dclk_fine #(.DIV_W(DIV_W), .BASE(BASE)) u_fine (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en),
        .tick  (pre_tick),
        .div   (st_q.div_sh),
        .wrap  (fine_wrap)
    );

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.ps_sh  = ps_sel;
            st_d.div_sh = div_sel;
            st_d.pulse  = 1'b0;
            st_d.level  = 1'b0;
        end else begin
            st_d.pulse = fine_wrap;
            st_d.level = st_q.level ^ fine_wrap;
            if (fine_wrap) begin
                st_d.ps_sh  = ps_sel;
                st_d.div_sh = div_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_pulse = st_q.pulse;
    assign out_level = st_q.level;

    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!out_pulse && !out_level));

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_pulse |=> !out_pulse);

    assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> ((out_level != $past(out_level)) == out_pulse));

    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !out_pulse) |-> ($stable(st_q.ps_sh) && $stable(st_q.div_sh)));
endmodule

// File: tb/dclk_divider_bench.sv
module dclk_divider_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] ps_sel = '0;
    logic [3:0] div_sel = '0;
    logic       out_pulse;
    logic       out_level;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dclk_divider u_dclk_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ps_sel    (ps_sel),
        .div_sel   (div_sel),
        .out_pulse (out_pulse),
        .out_level (out_level)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period_of(input int ps, input int dv);
        return (1 << ps) * (16 + dv);
    endfunction

    // Counts rising edges until out_pulse is seen after one (sampled 1 time unit later)
    task automatic wait_pulse(output int cyc, input int limit);
        cyc = 0;
        do begin
            @(posedge clk); #1;
            cyc++;
        end while (!out_pulse && cyc < limit);
    endtask

    task automatic start(input int ps, input int dv);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        ps_sel  = 4'(ps);
        div_sel = 4'(dv);
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(out_pulse == 1'b0, "R1 reset pulse", int'(out_pulse), 0);
        chk(out_level == 1'b0, "R1 reset level", int'(out_level), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(posedge clk);
        #1;
        chk(out_pulse == 1'b0, "R1 idle pulse", int'(out_pulse), 0);
    endtask

    // First-pulse latency, width, level and a number of further intervals
    task automatic test_period(input int ps, input int dv, input int nper, input string req);
        int c;
        int n;
        bit lvl;
        n = period_of(ps, dv);
        start(ps, dv);
        wait_pulse(c, n + 8);
        chk(c == n, "R4 first pulse latency", c, n);
        chk(out_level == 1'b1, "R6 level after first pulse", int'(out_level), 1);
        lvl = out_level;
        for (int k = 0; k < nper; k++) begin
            @(posedge clk); #1;
            chk(out_pulse == 1'b0, "R5 pulse width", int'(out_pulse), 0);
            wait_pulse(c, n + 8);
            c = c + 1;
            chk(c == n, req, c, n);
            chk(out_level == !lvl, "R6 level toggles", int'(out_level), int'(!lvl));
            lvl = out_level;
        end
    endtask

    task automatic test_change_mid();
        int c;
        start(0, 0);
        wait_pulse(c, 40);
        chk(c == 16, "R7 pre-change first period", c, 16);
        @(negedge clk);
        div_sel = 4'd4;
        wait_pulse(c, 40);
        chk(c == 16, "R7 running period keeps old length", c, 16);
        wait_pulse(c, 40);
        chk(c == 20, "R7 new period after wrap", c, 20);
    endtask

    task automatic test_disable_mid();
        int c;
        start(0, 0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        en = 1'b0;
        @(posedge clk); #1;
        chk(out_pulse == 1'b0 && out_level == 1'b0, "R1 disable clears outputs",
            int'({out_pulse, out_level}), 0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        en = 1'b1;
        wait_pulse(c, 40);
        chk(c == 16, "R8 re-enable restarts full period", c, 16);
    endtask

    task automatic test_max_fields();
        int c;
        start(15, 15);
        wait_pulse(c, 20000);
        chk(c == 20000 && out_pulse == 1'b0, "R3 ps15/div15 no early pulse", c, 20000);
        @(negedge clk);
        en = 1'b0;
        @(posedge clk); #1;
        chk(out_level == 1'b0, "R1 level cleared after disable", int'(out_level), 0);
    endtask

    initial begin
        test_reset();
        test_period(0, 0, 3, "R2 ps0/div0 interval");
        test_period(3, 5, 2, "R3 ps3/div5 interval");
        test_period(1, 15, 2, "R9 ps1/div15 interval");
        test_period(7, 9, 1, "R3 ps7/div9 interval");
        test_period(10, 15, 1, "R3 ps10/div15 interval");
        test_change_mid();
        test_disable_mid();
        test_max_fields();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R3 watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end
endmodule